// File: doc/BRIEF.md
# Missing Sync Pulse Lock Monitor

This block decides, separately for the horizontal and the vertical axis, whether a video decoder's timing is locked to the incoming sync pulses. An external period timer marks the end of each expected sync window with a one-cycle close strobe. The block records whether a separated sync pulse arrived during that window. Each closure then counts as a hit or as a miss. While an axis is locked, consecutive misses are counted. When the count reaches a limit chosen by a select bit, the axis falls into its acquisition state and a one-cycle lock-loss pulse is raised. While an axis is acquiring, consecutive hits are counted, and the axis returns to the locked state after four of them in a row.

Each axis runs a two-state machine: `ST_LOCKED` and `ST_ACQUIRE`. It has two transitions. The *miss-limit* transition goes from `ST_LOCKED` to `ST_ACQUIRE`. The *relock* transition goes from `ST_ACQUIRE` to `ST_LOCKED`. Both axes leave reset in `ST_ACQUIRE`. The two machines run independently, with one exception. While the horizontal axis is not locked, vertical window closures are ignored, so the vertical state and counters hold.

Top module: `sync_lock_monitor`

## Requirements
- R1: A window closure is a hit when a sync pulse was seen in any cycle since the previous closure, including the closing cycle itself. Otherwise the closure is a miss. Each closure clears the record of seen pulses.
- R2: With `h_short_sel`=0, the horizontal axis takes the miss-limit transition on the 12th consecutive miss while locked. It stays locked through 11 misses.
- R3: With `h_short_sel`=1, a single horizontal miss while locked takes the miss-limit transition.
- R4: With `v_short_sel`=0, the vertical axis takes the miss-limit transition on the 3rd consecutive miss while locked. It stays locked through 2 misses.
- R5: With `v_short_sel`=1, a single vertical miss while locked takes the miss-limit transition.
- R6: A hit on a locked axis clears its consecutive-miss count.
- R7: An acquiring axis takes the relock transition on its 4th consecutive hit. A miss while acquiring restarts the hit count from zero.
- R8: `lock_loss` is high for exactly the one cycle in which an axis first shows the acquiring state after a miss-limit transition. State outputs and `lock_loss` update in the cycle after the deciding closure.
- R9: While `h_locked` is 0, vertical sync pulses and closures have no effect. The vertical state, its counts and its seen-pulse record all hold or stay clear.
- R10: After reset, both axes are acquiring, both locked outputs are 0, `lock_loss` is 0, and all counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sync | input | 1 | Separated horizontal sync pulse |
| h_win_close | input | 1 | End of the expected horizontal window (one-cycle strobe) |
| v_sync | input | 1 | Separated vertical sync pulse |
| v_win_close | input | 1 | End of the expected vertical window (one-cycle strobe) |
| h_short_sel | input | 1 | Horizontal miss limit: 0 selects 12, 1 selects 1 |
| v_short_sel | input | 1 | Vertical miss limit: 0 selects 3, 1 selects 1 |
| h_locked | output | 1 | Horizontal axis in `ST_LOCKED` |
| h_acquiring | output | 1 | Horizontal axis in `ST_ACQUIRE` |
| v_locked | output | 1 | Vertical axis in `ST_LOCKED` |
| v_acquiring | output | 1 | Vertical axis in `ST_ACQUIRE` |
| lock_loss | output | 1 | One-cycle pulse on any miss-limit transition |

## Verification
Directed runs cover the following patterns:
- Miss runs one short of each limit, then broken by a hit. These show whether a hit truly clears the count.
- Runs of exactly the limit. These separate a limit of N from N±1.
- A sync pulse that lands in the closing cycle. This tells a same-cycle hit apart from a miss.
- Hit runs interrupted by a miss during acquisition. These show whether the relock count restarts.

Vertical traffic is also driven while the horizontal axis is acquiring, to show the suspension. A long pseudo-random phase then mixes pulses, closures and select changes.

// File: rtl/lock_mon_pkg.sv
package lock_mon_pkg;
    typedef enum logic {
        ST_ACQUIRE = 1'b0,
        ST_LOCKED  = 1'b1
    } lock_st_e;
endpackage

// File: rtl/sync_window.sv
module sync_window (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sync_i,
    input  logic close_i,
    output logic hit_o,
    output logic miss_o
);
    logic seen_q;
    logic seen_now;

    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else if (!en_i || close_i)
            seen_q <= 1'b0;
        else if (sync_i)
            seen_q <= 1'b1;
    end

    always_comb begin
        seen_now = seen_q | sync_i;
        hit_o    = en_i & close_i & seen_now;
        miss_o   = en_i & close_i & ~seen_now;
    end

    // R1: a pulse recorded in the previous cycle with no closure makes the next closure a hit
    p_seen_carries_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sync_i && !close_i) |=> (!en_i || !close_i || hit_o));
endmodule

// File: rtl/axis_fsm.sv
module axis_fsm
    import lock_mon_pkg::*;
#(
    parameter int LONG_MISS   = 12,
    parameter int SHORT_MISS  = 1,
    parameter int RELOCK_HITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic miss_i,
    input  logic short_sel_i,
    output logic locked_o,
    output logic loss_o
);
    localparam int MAXC = (LONG_MISS > RELOCK_HITS) ? LONG_MISS : RELOCK_HITS;
    localparam int CW   = $clog2(MAXC + 1);

    lock_st_e       state_q, state_d;
    logic [CW-1:0]  miss_q, miss_d;
    logic [CW-1:0]  good_q, good_d;
    logic [CW-1:0]  limit;
    logic           loss_d;

    assign limit = short_sel_i ? CW'(SHORT_MISS) : CW'(LONG_MISS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACQUIRE;
            miss_q  <= '0;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            miss_q  <= miss_d;
            good_q  <= good_d;
        end
    end

    always_comb begin
        state_d = state_q;
        miss_d  = miss_q;
        good_d  = good_q;
        loss_d  = 1'b0;
        unique case (state_q)
            ST_LOCKED: begin
                if (hit_i) begin
                    miss_d = '0;
                end else if (miss_i) begin
                    if ((miss_q + CW'(1)) >= limit) begin
                        state_d = ST_ACQUIRE;  // miss-limit transition
                        miss_d  = '0;
                        good_d  = '0;
                        loss_d  = 1'b1;
                    end else begin
                        miss_d = miss_q + CW'(1);
                    end
                end
            end
            ST_ACQUIRE: begin
                if (hit_i) begin
                    if ((good_q + CW'(1)) >= CW'(RELOCK_HITS)) begin
                        state_d = ST_LOCKED;  // relock transition
                        good_d  = '0;
                        miss_d  = '0;
                    end else begin
                        good_d = good_q + CW'(1);
                    end
                end else if (miss_i) begin
                    good_d = '0;
                end
            end
            default: state_d = ST_ACQUIRE;
        endcase
    end

    always_comb begin
        locked_o = (state_q == ST_LOCKED);
        loss_o   = loss_d;
    end

    // R3 / R5: short limit drops lock on one miss
    p_short_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && miss_i && short_sel_i) |=> !locked_o);
    // R6: a hit keeps a locked axis locked
    p_hit_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && hit_i) |=> locked_o);
    // R7: relock only follows a hit
    p_relock_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(hit_i));
    // R2 / R4: the miss count never reaches the long limit while locked
    p_miss_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (miss_q < CW'(LONG_MISS)));
endmodule

// File: rtl/sync_lock_monitor.sv
module sync_lock_monitor
    import lock_mon_pkg::*;
#(
    parameter int H_LONG_MISS = 12,
    parameter int V_LONG_MISS = 3,
    parameter int RELOCK_HITS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic h_sync,
    input  logic h_win_close,
    input  logic v_sync,
    input  logic v_win_close,
    input  logic h_short_sel,
    input  logic v_short_sel,
    output logic h_locked,
    output logic h_acquiring,
    output logic v_locked,
    output logic v_acquiring,
    output logic lock_loss
);
    logic h_hit, h_miss, v_hit, v_miss;
    logic h_lk, v_lk, h_loss, v_loss;
    logic loss_q;

    sync_window u_hwin (
        .clk(clk), .rst_n(rst_n), .en_i(1'b1),
        .sync_i(h_sync), .close_i(h_win_close),
        .hit_o(h_hit), .miss_o(h_miss)
    );

    sync_window u_vwin (
        .clk(clk), .rst_n(rst_n), .en_i(h_lk),
        .sync_i(v_sync), .close_i(v_win_close),
        .hit_o(v_hit), .miss_o(v_miss)
    );

    axis_fsm #(.LONG_MISS(H_LONG_MISS), .SHORT_MISS(1), .RELOCK_HITS(RELOCK_HITS)) u_hfsm (
        .clk(clk), .rst_n(rst_n), .hit_i(h_hit), .miss_i(h_miss),
        .short_sel_i(h_short_sel), .locked_o(h_lk), .loss_o(h_loss)
    );

    axis_fsm #(.LONG_MISS(V_LONG_MISS), .SHORT_MISS(1), .RELOCK_HITS(RELOCK_HITS)) u_vfsm (
        .clk(clk), .rst_n(rst_n), .hit_i(v_hit), .miss_i(v_miss),
        .short_sel_i(v_short_sel), .locked_o(v_lk), .loss_o(v_loss)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) loss_q <= 1'b0;
        else        loss_q <= h_loss | v_loss;
    end

    always_comb begin
        h_locked    = h_lk;
        h_acquiring = ~h_lk;
        v_locked    = v_lk;
        v_acquiring = ~v_lk;
        lock_loss   = loss_q;
    end

    // R8: a loss pulse coincides with an axis leaving lock
    p_loss_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_loss |-> ($fell(h_locked) || $fell(v_locked)));
    // R8: every lock drop is flagged
    p_drop_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(h_locked) || $fell(v_locked)) |-> lock_loss);
    // R9: vertical state frozen while horizontal is acquiring
    p_vert_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !h_locked |=> $stable(v_locked));
    // R10: outputs are complementary
    p_state_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({h_locked, h_acquiring}) && $onehot({v_locked, v_acquiring}));
endmodule

// File: tb/tb_sync_lock_monitor.sv
module tb_sync_lock_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_sync = 0, h_win_close = 0, v_sync = 0, v_win_close = 0;
    logic h_short_sel = 1'b1, v_short_sel = 1'b0;
    logic h_locked, h_acquiring, v_locked, v_acquiring, lock_loss;

    int checks = 0;
    int errors = 0;
    string cur_req = "R10";

    // reference model state
    bit m_hlk = 0, m_vlk = 0, m_loss = 0;
    bit m_hseen = 0, m_vseen = 0;
    int m_hmiss = 0, m_vmiss = 0, m_hgood = 0, m_vgood = 0;

    always #2 clk = ~clk;

    sync_lock_monitor dut (
        .clk(clk), .rst_n(rst_n),
        .h_sync(h_sync), .h_win_close(h_win_close),
        .v_sync(v_sync), .v_win_close(v_win_close),
        .h_short_sel(h_short_sel), .v_short_sel(v_short_sel),
        .h_locked(h_locked), .h_acquiring(h_acquiring),
        .v_locked(v_locked), .v_acquiring(v_acquiring),
        .lock_loss(lock_loss)
    );

    always @(posedge clk) begin
        bit v_en, hh, hm, vh, vm, nl;
        if (!rst_n) begin
            m_hlk = 0; m_vlk = 0; m_loss = 0; m_hseen = 0; m_vseen = 0;
            m_hmiss = 0; m_vmiss = 0; m_hgood = 0; m_vgood = 0;
        end else begin
            v_en = m_hlk;
            hh = h_win_close && (m_hseen || h_sync);
            hm = h_win_close && !(m_hseen || h_sync);
            m_hseen = h_win_close ? 0 : (m_hseen || h_sync);
            vh = v_en && v_win_close && (m_vseen || v_sync);
            vm = v_en && v_win_close && !(m_vseen || v_sync);
            m_vseen = (!v_en || v_win_close) ? 0 : (m_vseen || v_sync);
            nl = 0;
            if (m_hlk) begin
                if (hh) m_hmiss = 0;
                else if (hm) begin
                    m_hmiss++;
                    if (m_hmiss >= (h_short_sel ? 1 : 12)) begin
                        m_hlk = 0; m_hmiss = 0; m_hgood = 0; nl = 1;
                    end
                end
            end else begin
                if (hh) begin
                    m_hgood++;
                    if (m_hgood >= 4) begin m_hlk = 1; m_hgood = 0; m_hmiss = 0; end
                end else if (hm) m_hgood = 0;
            end
            if (m_vlk) begin
                if (vh) m_vmiss = 0;
                else if (vm) begin
                    m_vmiss++;
                    if (m_vmiss >= (v_short_sel ? 1 : 3)) begin
                        m_vlk = 0; m_vmiss = 0; m_vgood = 0; nl = 1;
                    end
                end
            end else begin
                if (vh) begin
                    m_vgood++;
                    if (m_vgood >= 4) begin m_vlk = 1; m_vgood = 0; m_vmiss = 0; end
                end else if (vm) m_vgood = 0;
            end
            m_loss = nl;
        end
    end

    task automatic chk(input string nm, input logic act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("h_locked", h_locked, m_hlk);
        chk("h_acquiring", h_acquiring, !m_hlk);
        chk("v_locked", v_locked, m_vlk);
        chk("v_acquiring", v_acquiring, !m_vlk);
        chk("lock_loss", lock_loss, m_loss);
    endtask

    task automatic cyc(input bit hs, input bit hw, input bit vs, input bit vw);
        @(negedge clk);
        compare_all();
        h_sync = hs; h_win_close = hw; v_sync = vs; v_win_close = vw;
    endtask

    task automatic hhit(input int n);
        for (int i = 0; i < n; i++) begin cyc(1, 0, 0, 0); cyc(0, 1, 0, 0); end
    endtask
    task automatic hmiss(input int n);
        for (int i = 0; i < n; i++) begin cyc(0, 0, 0, 0); cyc(0, 1, 0, 0); end
    endtask
    task automatic vhit(input int n);
        for (int i = 0; i < n; i++) begin cyc(1, 0, 1, 0); cyc(0, 1, 0, 1); end
    endtask
    task automatic vmiss(input int n);
        for (int i = 0; i < n; i++) begin cyc(1, 0, 0, 0); cyc(0, 1, 0, 1); end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cur_req = "R10";
        repeat (3) cyc(0, 0, 0, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cur_req = "R7";
        hhit(3); hmiss(1); hhit(3);
        cur_req = "R1";
        cyc(0, 0, 0, 0); cyc(1, 1, 0, 0);      // pulse in closing cycle: 4th hit
        cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        cur_req = "R7";
        vhit(2); vmiss(1); vhit(4); hhit(2);
        h_short_sel = 1'b0;
        cur_req = "R6";
        hmiss(11); hhit(1); hmiss(11);
        cur_req = "R2";
        hmiss(1); cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
        cur_req = "R9";
        v_short_sel = 1'b1;
        vmiss(3); vhit(2);
        cur_req = "R7";
        hhit(4); hhit(1);
        cur_req = "R4";
        v_short_sel = 1'b0;
        vmiss(2); vhit(1); vmiss(2); vmiss(1); cyc(1, 0, 0, 0);
        vhit(4);
        cur_req = "R5";
        v_short_sel = 1'b1;
        vmiss(1); cyc(1, 0, 0, 0); vhit(4);
        cur_req = "R3";
        h_short_sel = 1'b1;
        hmiss(1); cyc(0, 0, 0, 0); hhit(4);
        cur_req = "R8";
        for (int i = 0; i < 6000; i++) begin
            if (i % 700 == 0) begin h_short_sel = $urandom_range(0, 1); v_short_sel = $urandom_range(0, 1); end
            cyc(($urandom_range(0, 9) < 3), ($urandom_range(0, 9) < 2),
                ($urandom_range(0, 9) < 4), ($urandom_range(0, 9) < 2));
        end
        cyc(0, 0, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule